// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a 16-bit memory bus and an instruction decoder. It keeps up to six instruction bytes in arrival order. It refills itself by issuing word-wide code reads at a 16-bit fetch offset. That offset is added to a code segment base shifted left by four bits, which forms a 20-bit physical address. The decoder takes bytes from the front through a valid/ready handshake and stalls while the queue is empty.

The execution side shares the bus. While it holds a request, no new code read starts, and it is granted the bus whenever no code read is outstanding. A redirect, such as a jump, call or return, loads a new fetch offset. It empties the queue at once and throws away the data of any code read still in flight. If the new offset is odd, the first read delivers only its upper byte.

Top module: `prefetch_byte_queue`

## Requirements
- R1: The queue never holds more than six bytes, and bytes leave on `byte_o` in the exact order they arrived.
- R2: A completed word read at an even offset enqueues two bytes: `mem_rdata_i[7:0]` (even address) first, then `mem_rdata_i[15:8]`.
- R3: A code read is started only when at least two of the six slots are free in the cycle it is launched.
- R4: No code read is launched in a cycle where `exec_req_i` is high, and `exec_gnt_o` equals `exec_req_i` while no code read is outstanding and is low otherwise.
- R5: `byte_valid_o` is high exactly when the queue is non-empty and no redirect is present. A byte is removed only in a cycle where both valid and `byte_ready_i` are high.
- R6: A redirect empties the queue in the same cycle. A code read that is outstanding at the redirect, or completes in that cycle, enqueues nothing.
- R7: `mem_addr_o` equals (`code_seg_i` × 16 + fetch offset) modulo 2^20 with bit 0 cleared, sampled when the read is launched.
- R8: The fetch offset is loaded from `redirect_addr_i` on a redirect and advances by two after each completed, kept read from an even offset. It resets to zero.
- R9: A completed read from an odd offset enqueues only `mem_rdata_i[15:8]` and advances the offset by one.
- R10: When a redirect and a pop request occur in the same cycle, the redirect wins and no byte is handed over.
- R11: Once `mem_req_o` rises, it stays high with a stable `mem_addr_o` until the cycle in which `mem_ack_i` is high, and it drops in the following cycle.
- R12: During and after reset, `mem_req_o` and `byte_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_seg_i | input | 16 | Code segment base, sampled at read launch |
| redirect_i | input | 1 | Non-sequential flow: flush and reload offset |
| redirect_addr_i | input | 16 | New fetch offset loaded on redirect |
| exec_req_i | input | 1 | Execution side requests the bus |
| exec_gnt_o | output | 1 | Bus granted to execution side |
| mem_req_o | output | 1 | Code read request |
| mem_addr_o | output | 20 | Word-aligned physical code address |
| mem_ack_i | input | 1 | Code read completes this cycle |
| mem_rdata_i | input | 16 | Read data, low byte at even address |
| byte_o | output | 8 | Byte at the queue front |
| byte_valid_o | output | 1 | Front byte is available |
| byte_ready_i | input | 1 | Consumer takes the front byte |

## Verification
A wrong fill count or a stale pointer shows up at the ports within a few cycles. Either a read is launched with fewer than two free slots, or a byte appears out of sequence on `byte_o`, often right after the queue fills. A corrupted fetch offset shows up as a wrong `mem_addr_o` on the very next launch. A missed discard after a redirect shows up as bytes from the old flow reaching the consumer once the read that was in flight completes. The bench compares every output against a behavioural model on every cycle, so each of these is caught in the cycle it becomes visible.

// File: rtl/pbq_pkg.sv
package pbq_pkg;
  localparam int OFF_W  = 16;
  localparam int SEG_W  = 16;
  localparam int PHYS_W = 20;
  localparam int WORD_W = 16;
  typedef logic [7:0] qbyte_t;
endpackage

// File: rtl/pbq_store.sv
module pbq_store #(
  parameter int DEPTH = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic [1:0]                   push_n_i,
  input  logic [15:0]                  push_data_i,
  input  logic                         pop_i,
  output pbq_pkg::qbyte_t              head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  pbq_pkg::qbyte_t slot_q [DEPTH];
  logic [IW-1:0] rd_q, rd_d, wr_q, wr_d, wr_nx;
  logic [CW-1:0] count_q, count_d;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_nx = wrap_inc(wr_q);
    rd_d = rd_q;
    wr_d = wr_q;
    count_d = count_q;
    if (clr_i) begin
      rd_d = '0;
      wr_d = '0;
      count_d = '0;
    end else begin
      if (pop_i) rd_d = wrap_inc(rd_q);
      if (push_n_i == 2'd1) wr_d = wr_nx;
      else if (push_n_i == 2'd2) wr_d = wrap_inc(wr_nx);
      count_d = count_q + CW'(push_n_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      wr_q <= '0;
      count_q <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!clr_i && push_n_i != 2'd0 && wr_q == IW'(i))
        slot_q[i] <= push_data_i[7:0];
      else if (!clr_i && push_n_i == 2'd2 && wr_nx == IW'(i))
        slot_q[i] <= push_data_i[15:8];
    end
  end

  assign head_o  = slot_q[rd_q];
  assign count_o = count_q;

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH))
    else $error("queue count above capacity");

  assert_no_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0)
    else $error("pop from empty queue");
endmodule

// File: rtl/pbq_fetch.sv
module pbq_fetch (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic [15:0] target_i,
  input  logic [15:0] seg_i,
  input  logic        exec_req_i,
  input  logic        room_ok_i,
  input  logic        mem_ack_i,
  input  logic [15:0] mem_rdata_i,
  output logic        mem_req_o,
  output logic [19:0] mem_addr_o,
  output logic [1:0]  push_n_o,
  output logic [15:0] push_data_o
);
  import pbq_pkg::*;

  logic busy_q, busy_d, drop_q, drop_d, odd_q, odd_d;
  logic [OFF_W-1:0]  ptr_q, ptr_d;
  logic [PHYS_W-1:0] addr_q, addr_d, phys;
  logic launch, done, keep;

  assign phys   = {seg_i, 4'h0} + {4'h0, ptr_q};
  assign launch = !busy_q && !flush_i && !exec_req_i && room_ok_i;
  assign done   = busy_q && mem_ack_i;
  assign keep   = done && !drop_q && !flush_i;

  always_comb begin
    busy_d = busy_q;
    drop_d = drop_q;
    odd_d  = odd_q;
    addr_d = addr_q;
    ptr_d  = ptr_q;
    if (launch) begin
      busy_d = 1'b1;
      odd_d  = ptr_q[0];
      addr_d = {phys[PHYS_W-1:1], 1'b0};
    end else if (done) begin
      busy_d = 1'b0;
    end
    if (done) drop_d = 1'b0;
    else if (flush_i && busy_q) drop_d = 1'b1;
    if (flush_i) ptr_d = target_i;
    else if (keep) ptr_d = ptr_q + (odd_q ? 16'd1 : 16'd2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      odd_q  <= 1'b0;
      addr_q <= '0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      drop_q <= drop_d;
      odd_q  <= odd_d;
      addr_q <= addr_d;
      ptr_q  <= ptr_d;
    end
  end

  assign mem_req_o   = busy_q;
  assign mem_addr_o  = addr_q;
  assign push_n_o    = keep ? (odd_q ? 2'd1 : 2'd2) : 2'd0;
  assign push_data_o = odd_q ? {8'h00, mem_rdata_i[15:8]} : mem_rdata_i;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o))
    else $error("request dropped or address moved before ack");

  assert_req_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o)
    else $error("request not released after ack");
endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue #(
  parameter int DEPTH = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] code_seg_i,
  input  logic        redirect_i,
  input  logic [15:0] redirect_addr_i,
  input  logic        exec_req_i,
  output logic        exec_gnt_o,
  output logic        mem_req_o,
  output logic [19:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [15:0] mem_rdata_i,
  output logic [7:0]  byte_o,
  output logic        byte_valid_o,
  input  logic        byte_ready_i
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] count;
  logic [1:0]    push_n;
  logic [15:0]   push_data;
  logic          room_ok, pop;

  assign room_ok      = (CW'(DEPTH) - count) >= CW'(2);
  assign byte_valid_o = (count != '0) && !redirect_i;
  assign pop          = byte_valid_o && byte_ready_i;
  assign exec_gnt_o   = exec_req_i && !mem_req_o;

  pbq_fetch u_fetch (
    .clk_i, .rst_ni,
    .flush_i     (redirect_i),
    .target_i    (redirect_addr_i),
    .seg_i       (code_seg_i),
    .exec_req_i,
    .room_ok_i   (room_ok),
    .mem_ack_i,
    .mem_rdata_i,
    .mem_req_o,
    .mem_addr_o,
    .push_n_o    (push_n),
    .push_data_o (push_data)
  );

  pbq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .clr_i       (redirect_i),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (byte_o),
    .count_o     (count)
  );

  assert_launch_room_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(count) <= CW'(DEPTH-2))
    else $error("code read launched without two free slots");

  assert_exec_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !$past(exec_req_i))
    else $error("code read launched over execution request");

  assert_flush_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !byte_valid_o)
    else $error("bytes survived a redirect");

  assert_flush_no_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i && !mem_req_o |=> !mem_req_o)
    else $error("read launched in redirect cycle");
endmodule

// File: tb/prefetch_byte_queue_tb_top.sv
module prefetch_byte_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] seg = 16'h0000, tgt = 16'h0000, rdata = 16'h0000;
  logic redir = 1'b0, exec_req = 1'b0, ack = 1'b0, ready = 1'b0;
  logic exec_gnt, mreq, bvalid;
  logic [19:0] maddr;
  logic [7:0] bdata;

  int vectors = 0, miscompares = 0, wd = 0;

  prefetch_byte_queue dut_i (
    .clk_i(clk), .rst_ni(rst_n), .code_seg_i(seg), .redirect_i(redir),
    .redirect_addr_i(tgt), .exec_req_i(exec_req), .exec_gnt_o(exec_gnt),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .byte_o(bdata), .byte_valid_o(bvalid), .byte_ready_i(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  byte unsigned q[$];
  bit m_busy = 0, m_drop = 0, m_odd = 0;
  logic [15:0] m_ptr = 16'h0;
  logic [19:0] m_addr = 20'h0;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_drop = 0; m_odd = 0; m_ptr = 0; m_addr = 0;
    end else begin
      bit launch, done, mvalid;
      mvalid = (q.size() != 0) && !redir;
      launch = !m_busy && !redir && !exec_req && (6 - q.size() >= 2);
      done   = m_busy && ack;
      if (redir) begin
        q.delete();
        m_ptr = tgt;
        m_drop = (m_busy && !ack);
        if (done) m_busy = 0;
      end else begin
        if (mvalid && ready) void'(q.pop_front());
        if (done) begin
          if (!m_drop) begin
            if (m_odd) begin q.push_back(rdata[15:8]); m_ptr = m_ptr + 1; end
            else begin q.push_back(rdata[7:0]); q.push_back(rdata[15:8]); m_ptr = m_ptr + 2; end
          end
          m_busy = 0; m_drop = 0;
        end
        if (launch) begin
          logic [19:0] p;
          p = {seg, 4'h0} + {4'h0, m_ptr};
          m_busy = 1; m_odd = m_ptr[0]; m_addr = {p[19:1], 1'b0};
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit mv;
    mv = (q.size() != 0) && !redir;
    chk({tag, " R5"}, "byte_valid", 32'(bvalid), 32'(mv));
    if (mv) chk({tag, " R1 R2"}, "byte", 32'(bdata), 32'(q[0]));
    chk({tag, " R11"}, "mem_req", 32'(mreq), 32'(m_busy));
    if (m_busy) chk({tag, " R7"}, "mem_addr", 32'(maddr), 32'(m_addr));
    chk({tag, " R4"}, "exec_gnt", 32'(exec_gnt), 32'(exec_req && !m_busy));
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int lat = 0, wcnt = 0;
    string tag;
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "reset mem_req", 32'(mreq), 32'd0);
    chk("R12", "reset byte_valid", 32'(bvalid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      redir = 1'b0; exec_req = 1'b0; ready = 1'b1; seg = 16'h1234;
      if (cyc < 40) begin
        tag = "R8 R12";
        if (cyc == 0) begin redir = 1'b1; tgt = 16'h0100; end
      end else if (cyc < 80) begin
        tag = "R1 R3";
        ready = 1'b0;
      end else if (cyc < 120) begin
        tag = "R4";
        exec_req = (cyc < 96) || lfsr[0];
        ready = cyc[0];
      end else if (cyc < 150) begin
        tag = "R9";
        if (cyc == 120) begin redir = 1'b1; tgt = 16'h2001; end
        if (cyc == 140) begin redir = 1'b1; tgt = 16'hFFFF; seg = 16'hFFFF; end
      end else if (cyc < 250) begin
        tag = "R6 R10";
        redir = (cyc % 9 == 0) || (m_busy && lfsr[3:0] == 4'h0);
        tgt = lfsr ^ 16'h5A5A;
      end else begin
        tag = "R5 R11";
        redir = (lfsr[5:0] == 6'h00);
        tgt = {lfsr[7:0], lfsr[15:8]};
        exec_req = lfsr[2] & lfsr[6];
        ready = lfsr[1] | lfsr[9];
        seg = {lfsr[11:4], 8'h10};
      end
      ack = 1'b0;
      if (m_busy) begin
        if (wcnt >= lat) begin
          ack = 1'b1; wcnt = 0; lat = int'(lfsr[15:14]);
        end else wcnt++;
      end
      rdata = {mem_byte(m_addr + 20'h1), mem_byte(m_addr)};
      #1;
      compare(tag);
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule